// File: doc/BRIEF.md
# Quarter-Arc Digital Differential Analyzer

This block makes the step pulses that trace a counter-clockwise arc in the first quadrant. Motion runs from a start point toward the y axis, so each x pulse moves one unit in negative x and each y pulse moves one unit in positive y. There are two integrators. The x-axis integrator adds the current y coordinate into its remainder on every clock. The y-axis integrator adds the current x coordinate. A carry out of a remainder emits a pulse on that axis, and the pulse changes the coordinate held by the other integrator before the next iteration.

Each axis counts down its own number of steps and stops by itself when the count reaches zero. Near the end of the arc one coordinate arrives first, and it must not run past its target while the other axis keeps going. The caller supplies the start point and the two step counts, then strobes `start`. The remainders can be preset to empty, to half capacity or to full capacity. A non-empty preset fires the first pulses earlier and lowers the error of the traced path.

Top module: `ddaArcInterp`

## Requirements
- R1: After reset, `done` is 1 and both step outputs are 0.
- R2: When `start` is 1 in a cycle where `done` is 1, the block loads the start point, both step counts and the preset. `done` falls one clock later if either count is nonzero.
- R3: While x steps remain, every clock adds the y coordinate to the x remainder (W bits). A carry out of bit W produces a one-cycle `stepX` pulse in the next cycle.
- R4: While y steps remain, every clock adds the x coordinate to the y remainder. A carry produces a one-cycle `stepY` pulse in the next cycle.
- R5: Each x pulse lowers the x coordinate by one and each y pulse raises the y coordinate by one. Both changes take effect at the same edge as the pulse, so the next iteration uses the new values.
- R6: Over one run, the number of `stepX` pulses equals `xSteps` and the number of `stepY` pulses equals `ySteps`. An axis whose count has reached zero stops accumulating and emits no pulses.
- R7: `done` rises in the same cycle as the last pulse of the run. It stays 1 with no pulses until the next accepted `start`.
- R8: `presetMode` selects the initial value of both remainders:
  - 0: zero.
  - 1: only the most significant bit set.
  - 2: all ones, which is 2^W−1.
  - 3: zero, the same as 0.
- R9: `start` has no effect while `done` is 0, and the pulse sequence of the run in progress does not change.
- R10: An axis loaded with a step count of zero emits no pulse during the run. The other axis still runs to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; accepted only when `done` is 1 |
| xStart | input | W | Start x coordinate |
| yStart | input | W | Start y coordinate |
| xSteps | input | W | Number of x pulses in the run |
| ySteps | input | W | Number of y pulses in the run |
| presetMode | input | 2 | Remainder preset: 0 zero, 1 half, 2 full, 3 zero |
| stepX | output | 1 | One-cycle pulse: move one unit in −x |
| stepY | output | 1 | One-cycle pulse: move one unit in +y |
| done | output | 1 | Both step counts exhausted; block idle |

## Verification
The hardest situation to reach from the ports is a `start` strobe that arrives in the middle of a run with different coordinates and counts. A mistake there corrupts the run in progress, and it shows only as a shifted pulse pattern much later. The stimulus injects such a strobe a few cycles into a long half-preset run, and the per-cycle pulse comparison covers the rest of that run. Zero-count axes and the four preset codes get runs of their own. Arcs that start on the x axis cover the near-axis case, where one integrand is zero while the other is at the radius.

// File: rtl/ddaArcPkg.sv
package ddaArcPkg;
  typedef enum logic [1:0] {
    PRESET_ZERO = 2'd0,
    PRESET_HALF = 2'd1,
    PRESET_FULL = 2'd2
  } presetMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // take new start point and preset
    logic accX;  // x axis still has steps to make
    logic accY;  // y axis still has steps to make
  } ddaStrobe_t;
endpackage

// File: rtl/ddaArcCtrl.sv
module ddaArcCtrl
  import ddaArcPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] xSteps,
  input  logic [W-1:0] ySteps,
  input  logic         carryX,
  input  logic         carryY,
  output ddaStrobe_t   strobe,
  output logic         done,
  output logic [W-1:0] xLeft,
  output logic [W-1:0] yLeft
);
  logic xActive, yActive;

  always_comb begin
    xActive     = (xLeft != '0);
    yActive     = (yLeft != '0);
    done        = !(xActive || yActive);
    strobe.load = start && done;
    strobe.accX = xActive;
    strobe.accY = yActive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xLeft <= '0;
      yLeft <= '0;
    end else if (strobe.load) begin
      xLeft <= xSteps;
      yLeft <= ySteps;
    end else begin
      if (xActive && carryX) xLeft <= xLeft - 1'b1;
      if (yActive && carryY) yLeft <= yLeft - 1'b1;
    end
  end
endmodule

// File: rtl/ddaArcPath.sv
module ddaArcPath
  import ddaArcPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ddaStrobe_t   strobe,
  input  logic [W-1:0] xStart,
  input  logic [W-1:0] yStart,
  input  logic [1:0]   presetMode,
  output logic         carryX,
  output logic         carryY,
  output logic         stepX,
  output logic         stepY,
  output logic [W-1:0] xInt,   // integrand of x axis = current y
  output logic [W-1:0] yInt    // integrand of y axis = current x
);
  localparam int SW = W + 1;

  logic [W-1:0]  xRem, yRem, presetVal;
  logic [SW-1:0] sumX, sumY;
  logic          fireX, fireY;

  always_comb begin
    case (presetMode)
      PRESET_HALF: presetVal = {1'b1, {(W-1){1'b0}}};
      PRESET_FULL: presetVal = '1;
      default:     presetVal = '0;
    endcase
    sumX   = {1'b0, xRem} + {1'b0, xInt};
    sumY   = {1'b0, yRem} + {1'b0, yInt};
    carryX = sumX[W];
    carryY = sumY[W];
    fireX  = strobe.accX && carryX;
    fireY  = strobe.accY && carryY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xInt  <= '0;
      yInt  <= '0;
      xRem  <= '0;
      yRem  <= '0;
      stepX <= 1'b0;
      stepY <= 1'b0;
    end else if (strobe.load) begin
      xInt  <= yStart;
      yInt  <= xStart;
      xRem  <= presetVal;
      yRem  <= presetVal;
      stepX <= 1'b0;
      stepY <= 1'b0;
    end else begin
      stepX <= fireX;
      stepY <= fireY;
      if (strobe.accX) xRem <= sumX[W-1:0];
      if (strobe.accY) yRem <= sumY[W-1:0];
      if (fireY) xInt <= xInt + 1'b1;  // y moved up
      if (fireX) yInt <= yInt - 1'b1;  // x moved left
    end
  end
endmodule

// File: rtl/ddaArcInterp.sv
module ddaArcInterp
  import ddaArcPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] xStart,
  input  logic [W-1:0] yStart,
  input  logic [W-1:0] xSteps,
  input  logic [W-1:0] ySteps,
  input  logic [1:0]   presetMode,
  output logic         stepX,
  output logic         stepY,
  output logic         done
);
  ddaStrobe_t   strobe;
  logic         carryX, carryY;
  logic [W-1:0] xLeft, yLeft, xInt, yInt;

  ddaArcCtrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .xSteps(xSteps), .ySteps(ySteps),
    .carryX(carryX), .carryY(carryY), .strobe(strobe), .done(done),
    .xLeft(xLeft), .yLeft(yLeft)
  );

  ddaArcPath #(.W(W)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .xStart(xStart), .yStart(yStart),
    .presetMode(presetMode), .carryX(carryX), .carryY(carryY),
    .stepX(stepX), .stepY(stepY), .xInt(xInt), .yInt(yInt)
  );
endmodule

// File: rtl/ddaArcChecker.sv
module ddaArcChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic         stepX,
  input logic         stepY,
  input logic [W-1:0] xSteps,
  input logic [W-1:0] ySteps,
  input logic [W-1:0] xLeft,
  input logic [W-1:0] yLeft,
  input logic [W-1:0] xInt,
  input logic [W-1:0] yInt
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (done && !stepX && !stepY));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && done && (xSteps != '0 || ySteps != '0)) |=> !done);

  p_x_count_r6: assert property (@(posedge clk) disable iff (rst)
    (stepX && !$past(rst)) |-> (xLeft == $past(xLeft) - 1'b1));

  p_y_count_r6: assert property (@(posedge clk) disable iff (rst)
    (stepY && !$past(rst)) |-> (yLeft == $past(yLeft) - 1'b1));

  p_x_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (stepX && !$past(rst)) |-> (yInt == $past(yInt) - 1'b1));

  p_y_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (stepY && !$past(rst)) |-> (xInt == $past(xInt) + 1'b1));

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done) && !$past(rst)) |-> (!stepX && !stepY));

  p_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
    !done |=> (xLeft <= $past(xLeft) && yLeft <= $past(yLeft)));
endmodule

bind ddaArcInterp ddaArcChecker #(.W(W)) u_ddaArcChecker (
  .clk(clk), .rst(rst), .start(start), .done(done), .stepX(stepX),
  .stepY(stepY), .xSteps(xSteps), .ySteps(ySteps), .xLeft(xLeft),
  .yLeft(yLeft), .xInt(xInt), .yInt(yInt)
);

// File: tb/test_ddaArcInterp.sv
module test_ddaArcInterp;
  localparam int W   = 8;
  localparam int CAP = 1 << W;

  typedef struct {
    bit sx;
    bit sy;
    bit dn;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] xStart = '0, yStart = '0, xSteps = '0, ySteps = '0;
  logic [1:0] presetMode = '0;
  logic stepX, stepY, done;

  int checks = 0;
  int errors = 0;
  int gotX = 0;
  int gotY = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;
  item_t q[$];

  always #4 clk = ~clk;

  ddaArcInterp #(.W(W)) i_ddaArcInterp (
    .clk(clk), .rst(rst), .start(start), .xStart(xStart), .yStart(yStart),
    .xSteps(xSteps), .ySteps(ySteps), .presetMode(presetMode),
    .stepX(stepX), .stepY(stepY), .done(done)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare each cycle against the scoreboard
  always @(negedge clk) begin
    if (armed && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(stepX === e.sx, "R3 stepX", int'(stepX), int'(e.sx));
      chk(stepY === e.sy, "R4 stepY", int'(stepY), int'(e.sy));
      chk(done === e.dn, "R2 R7 done", int'(done), int'(e.dn));
      gotX += int'(stepX === 1'b1);
      gotY += int'(stepY === 1'b1);
    end
  end

  // driver: model the run from the requirements, then launch it
  task automatic runArc(int xs, int ys, int nx, int ny, int mode, bit poke,
                        string tag);
    int xi = ys;
    int yi = xs;
    int xc = nx;
    int yc = ny;
    int pre;
    int xr;
    int yr;
    int n = 0;
    int k = 0;
    pre = (mode == 1) ? (CAP / 2) : (mode == 2) ? (CAP - 1) : 0;
    xr = pre;
    yr = pre;
    q.push_back('{1'b0, 1'b0, (nx == 0 && ny == 0)});
    while ((xc > 0 || yc > 0) && n < 4000) begin
      bit sx = 1'b0;
      bit sy = 1'b0;
      if (xc > 0) begin
        xr += xi;
        if (xr >= CAP) begin xr -= CAP; sx = 1'b1; end
      end
      if (yc > 0) begin
        yr += yi;
        if (yr >= CAP) begin yr -= CAP; sy = 1'b1; end
      end
      if (sx) begin xc--; yi--; end
      if (sy) begin yc--; xi++; end
      q.push_back('{sx, sy, (xc == 0 && yc == 0)});
      n++;
    end
    gotX = 0;
    gotY = 0;
    @(negedge clk);
    xStart = W'(xs); yStart = W'(ys);
    xSteps = W'(nx); ySteps = W'(ny);
    presetMode = 2'(mode);
    start = 1'b1;
    @(posedge clk);
    armed = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() > 0) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin
        // R9: strobe with other values while busy
        start = 1'b1;
        xStart = 8'd3; yStart = 8'd9;
        xSteps = 8'd1; ySteps = 8'd1;
        presetMode = 2'd2;
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0;
    armed = 1'b0;
    chk(gotX == nx, {"R6 x pulse total ", tag}, gotX, nx);
    chk(gotY == ny, {"R6 y pulse total ", tag}, gotY, ny);
    repeat (3) @(negedge clk);
    chk(done === 1'b1, {"R7 idle done ", tag}, int'(done), 1);
    chk(!stepX && !stepY, {"R7 idle quiet ", tag}, int'({stepX, stepY}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R1 done", int'(done), 1);
    chk(stepX === 1'b0, "R1 stepX", int'(stepX), 0);
    chk(stepY === 1'b0, "R1 stepY", int'(stepY), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, "R1 done after release", int'(done), 1);

    runArc(10, 0, 4, 8, 0, 1'b0, "R8 zero preset");
    runArc(10, 0, 4, 8, 1, 1'b0, "R8 half preset");
    runArc(10, 0, 4, 8, 2, 1'b0, "R8 full preset");
    runArc(10, 0, 4, 8, 3, 1'b0, "R8 code3 as zero");
    runArc(5, 0, 2, 4, 1, 1'b1, "R9 start while busy");
    runArc(10, 5, 3, 0, 2, 1'b0, "R10 y count zero");
    runArc(5, 5, 0, 3, 0, 1'b0, "R10 x count zero");
    runArc(8, 6, 2, 2, 1, 1'b0, "R5 mid arc");

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule